// File: doc/BRIEF.md
# Prioritized 64-Source Interrupt Controller

This block collects 64 level-sensitive interrupt request lines and reduces them to a single request for the processor. The request is a priority level plus a vector number. Each source has four pieces of state. A pending bit tracks its input line. A mask bit can block it. A force bit is read-only and is never set. An 8-bit control byte gives its priority and also enables it: a byte of zero disables the source.

A tree arbiter picks the winning active source. Its level and vector are registered and driven to the processor. When nothing is active, the level is 0 and the vector is the idle value 24.

Software reaches the state through a simple register port with an 8-bit byte offset and 32-bit data. Reads are combinational. A write is taken on the clock edge while the write strobe is high. A read at the acknowledge offset returns the vector currently presented. A write to an offset that cannot be written is dropped and flagged on a one-cycle error output.

Offset classes, as decoded by the offset decoder:

| Class | Offsets |
|---|---|
| `ACC_PEND_HI` | 0x00 |
| `ACC_PEND_LO` | 0x04 |
| `ACC_MASK_HI` | 0x08 |
| `ACC_MASK_LO` | 0x0C |
| `ACC_FRC_HI` | 0x10 |
| `ACC_FRC_LO` | 0x14 |
| `ACC_CTRL` | 0x40..0x7F |
| `ACC_ACK` | 0xE0 |
| `ACC_NONE` | every other offset |

The block has no sequential state machine. The output stage has two conditions:
- **idle**: no source is active.
- **granted**: some source is active.

On every clock it moves to whichever condition the previous cycle's active set selects.

Top module: `irq_prio_ctrl`

## Requirements
- R1: The pending bit of source n is a registered copy of `irq_in[n]`, updated on every clock. A read at offset 0x00 returns pending bits 63..32, and a read at 0x04 returns bits 31..0.
- R2: Source n is active only when all three hold: its pending bit is 1, its control byte is nonzero, and its mask bit is 0. A mask bit of 1 blocks the source, and so does a control byte of 0.
- R3: Among active sources, the one with the largest control byte wins. When two or more share that largest value, the one with the highest index wins.
- R4: The vector is the winning index plus 64, so source 0 gives 64 and source 63 gives 127. With no active source, the vector is 24 and the level is 0.
- R5: `cpu_level` equals the winner's control byte. Both `cpu_level` and `cpu_vector` are registers, computed from the state held during the previous cycle.
- R6: A write at 0x08 replaces mask bits 63..32 with the write data. A write at 0x0C replaces bits 31..0. The other half keeps its value. Reads at 0x08 and 0x0C return the two halves.
- R7: A write at offset 0x40+n stores data bits 7..0 as the control byte of source n. A read there returns that byte zero-extended to 32 bits.
- R8: Writes at 0x00 and 0x04 change no state and do not raise `wr_err`.
- R9: A read at 0xE0 returns the current `cpu_vector`, zero-extended. Reads at 0x10 and 0x14 (the force halves) return 0. Reads at any offset with no register return 0.
- R10: A write at any offset other than 0x00, 0x04, 0x08, 0x0C or 0x40..0x7F changes no state. `wr_err` is 1 in the cycle that follows that write and 0 in the cycle after it, unless the write is repeated.
- R11: After reset, the mask is all ones, pending, force and control bytes are all 0, `cpu_vector` is 24, `cpu_level` is 0 and `wr_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 64 | Level-sensitive interrupt request lines |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_off | input | 8 | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_off`, combinational |
| cpu_level | output | 8 | Priority level presented to the processor |
| cpu_vector | output | 8 | Vector number presented to the processor |
| wr_err | output | 1 | One-cycle flag for a write that was dropped |

## Verification
The assertions check the following on every cycle:
- pending tracks the request lines;
- a mask write keeps the other half unchanged;
- pending-offset writes never raise the error flag, and the flag only follows a write;
- no active source beats the granted one or ties it from a higher index;
- an empty active set always produces the idle vector with level 0.

Some behaviours only the bench's scenarios can show, because they need the bench's reference model and chosen stimulus:
- tie-breaking toward the higher index;
- disabling a source by writing a zero control byte;
- the contents of each read-back offset;
- the reset values.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int OFF_W = 8;

    localparam logic [OFF_W-1:0] OFF_PEND_HI = 8'h00;
    localparam logic [OFF_W-1:0] OFF_PEND_LO = 8'h04;
    localparam logic [OFF_W-1:0] OFF_MASK_HI = 8'h08;
    localparam logic [OFF_W-1:0] OFF_MASK_LO = 8'h0C;
    localparam logic [OFF_W-1:0] OFF_FRC_HI  = 8'h10;
    localparam logic [OFF_W-1:0] OFF_FRC_LO  = 8'h14;
    localparam logic [OFF_W-1:0] OFF_CTRL    = 8'h40;
    localparam logic [OFF_W-1:0] OFF_ACK     = 8'hE0;

    typedef enum logic [3:0] {
        ACC_NONE,
        ACC_PEND_HI,
        ACC_PEND_LO,
        ACC_MASK_HI,
        ACC_MASK_LO,
        ACC_FRC_HI,
        ACC_FRC_LO,
        ACC_CTRL,
        ACC_ACK
    } acc_e;

endpackage

// File: rtl/irq_off_decode.sv
module irq_off_decode
    import irq_prio_pkg::*;
#(
    parameter int N_SRC = 64
) (
    input  logic [OFF_W-1:0]         off,
    output acc_e                     kind,
    output logic [$clog2(N_SRC)-1:0] idx
);
    localparam int IDX_W = $clog2(N_SRC);

    logic [OFF_W-1:0] rel;

    always_comb begin
        rel  = off - OFF_CTRL;
        idx  = rel[IDX_W-1:0];
        kind = ACC_NONE;
        if (off >= OFF_CTRL && int'(rel) < N_SRC) begin
            kind = ACC_CTRL;
        end else begin
            unique case (off)
                OFF_PEND_HI: kind = ACC_PEND_HI;
                OFF_PEND_LO: kind = ACC_PEND_LO;
                OFF_MASK_HI: kind = ACC_MASK_HI;
                OFF_MASK_LO: kind = ACC_MASK_LO;
                OFF_FRC_HI:  kind = ACC_FRC_HI;
                OFF_FRC_LO:  kind = ACC_FRC_LO;
                OFF_ACK:     kind = ACC_ACK;
                default:     kind = ACC_NONE;
            endcase
        end
    end
endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank
    import irq_prio_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LVL_W  = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [2*DATA_W-1:0]                  irq_in,
    input  logic                                 wr_en,
    input  acc_e                                 wr_kind,
    input  logic [$clog2(2*DATA_W)-1:0]          wr_idx,
    input  logic [DATA_W-1:0]                    wdata,
    output logic [2*DATA_W-1:0]                  pend_q,
    output logic [2*DATA_W-1:0]                  mask_q,
    output logic [2*DATA_W-1:0]                  force_q,
    output logic [2*DATA_W-1:0][LVL_W-1:0]       ctrl_q,
    output logic [2*DATA_W-1:0]                  active,
    output logic                                 wr_err_q
);
    localparam int N_SRC = 2 * DATA_W;
    localparam int HALF  = DATA_W;
    localparam int IDX_W = $clog2(N_SRC);

    logic [N_SRC-1:0] enable;
    logic             wr_bad;

    // Pending tracks the request lines; force has no write path.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= '0;
            force_q <= '0;
        end else begin
            pend_q  <= irq_in;
            force_q <= force_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (wr_en) begin
            if (wr_kind == ACC_MASK_HI) mask_q[N_SRC-1:HALF] <= wdata;
            if (wr_kind == ACC_MASK_LO) mask_q[HALF-1:0]     <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            for (int i = 0; i < N_SRC; i++) begin
                if (wr_en && wr_kind == ACC_CTRL && wr_idx == IDX_W'(i))
                    ctrl_q[i] <= wdata[LVL_W-1:0];
            end
        end
    end

    always_comb begin
        unique case (wr_kind)
            ACC_PEND_HI, ACC_PEND_LO,
            ACC_MASK_HI, ACC_MASK_LO,
            ACC_CTRL:  wr_bad = 1'b0;
            default:   wr_bad = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_err_q <= 1'b0;
        else        wr_err_q <= wr_en && wr_bad;
    end

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign enable[g] = |ctrl_q[g];
        assign active[g] = (pend_q[g] | force_q[g]) & enable[g] & ~mask_q[g];
    end

    a_r1_pend_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> pend_q == $past(irq_in));

    a_r6_mask_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == ACC_MASK_HI) |=>
            (mask_q[HALF-1:0] == $past(mask_q[HALF-1:0]) &&
             mask_q[N_SRC-1:HALF] == $past(wdata)));

    a_r6_mask_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == ACC_MASK_LO) |=>
            (mask_q[N_SRC-1:HALF] == $past(mask_q[N_SRC-1:HALF]) &&
             mask_q[HALF-1:0] == $past(wdata)));

    a_r8_pend_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_kind == ACC_PEND_HI || wr_kind == ACC_PEND_LO)) |=> !wr_err_q);

    a_r10_err_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err_q |-> $past(wr_en));
endmodule

// File: rtl/irq_arb_tree.sv
module irq_arb_tree #(
    parameter int N_SRC = 64,
    parameter int LVL_W = 8
) (
    input  logic [N_SRC-1:0]            active,
    input  logic [N_SRC-1:0][LVL_W-1:0] ctrl,
    output logic                        found,
    output logic [$clog2(N_SRC)-1:0]    win_idx,
    output logic [LVL_W-1:0]            win_lvl
);
    localparam int IDX_W = $clog2(N_SRC);
    localparam int NODES = 2 * N_SRC - 1;
    localparam int LEAF0 = N_SRC - 1;

    logic [NODES-1:0]            nv;
    logic [NODES-1:0][IDX_W-1:0] ni;
    logic [NODES-1:0][LVL_W-1:0] nl;

    for (genvar i = 0; i < N_SRC; i++) begin : g_leaf
        assign nv[LEAF0+i] = active[i];
        assign ni[LEAF0+i] = IDX_W'(i);
        assign nl[LEAF0+i] = ctrl[i];
    end

    // Right child holds higher indices and wins ties.
    for (genvar k = 0; k < N_SRC - 1; k++) begin : g_node
        logic take_r;
        assign take_r = nv[2*k+2] && (!nv[2*k+1] || nl[2*k+2] >= nl[2*k+1]);
        assign nv[k]  = nv[2*k+1] | nv[2*k+2];
        assign ni[k]  = take_r ? ni[2*k+2] : ni[2*k+1];
        assign nl[k]  = take_r ? nl[2*k+2] : nl[2*k+1];
    end

    assign found   = nv[0];
    assign win_idx = ni[0];
    assign win_lvl = nl[0];

    always_comb begin
        for (int i = 0; i < N_SRC; i++) begin
            if (active[i]) begin
                a_r3_none_above: assert (found && ctrl[i] <= win_lvl);
                if (IDX_W'(i) > win_idx) begin
                    a_r3_tie_high_index: assert (ctrl[i] < win_lvl);
                end
            end
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int LVL_W    = 8,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 64,
    parameter int VEC_IDLE = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2*DATA_W-1:0]  irq_in,
    input  logic                 bus_wr,
    input  logic [OFF_W-1:0]     bus_off,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [LVL_W-1:0]     cpu_level,
    output logic [VEC_W-1:0]     cpu_vector,
    output logic                 wr_err
);
    localparam int N_SRC = 2 * DATA_W;
    localparam int HALF  = DATA_W;
    localparam int IDX_W = $clog2(N_SRC);

    acc_e                        kind;
    logic [IDX_W-1:0]            idx;
    logic [N_SRC-1:0]            pend_q;
    logic [N_SRC-1:0]            mask_q;
    logic [N_SRC-1:0]            force_q;
    logic [N_SRC-1:0][LVL_W-1:0] ctrl_q;
    logic [N_SRC-1:0]            active;
    logic                        found;
    logic [IDX_W-1:0]            win_idx;
    logic [LVL_W-1:0]            win_lvl;

    irq_off_decode #(.N_SRC(N_SRC)) u_dec (
        .off  (bus_off),
        .kind (kind),
        .idx  (idx)
    );

    irq_src_bank #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_in   (irq_in),
        .wr_en    (bus_wr),
        .wr_kind  (kind),
        .wr_idx   (idx),
        .wdata    (bus_wdata),
        .pend_q   (pend_q),
        .mask_q   (mask_q),
        .force_q  (force_q),
        .ctrl_q   (ctrl_q),
        .active   (active),
        .wr_err_q (wr_err)
    );

    irq_arb_tree #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_arb (
        .active  (active),
        .ctrl    (ctrl_q),
        .found   (found),
        .win_idx (win_idx),
        .win_lvl (win_lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_level  <= '0;
            cpu_vector <= VEC_W'(VEC_IDLE);
        end else if (found) begin
            cpu_level  <= win_lvl;
            cpu_vector <= VEC_W'(VEC_BASE) + VEC_W'(win_idx);
        end else begin
            cpu_level  <= '0;
            cpu_vector <= VEC_W'(VEC_IDLE);
        end
    end

    always_comb begin
        unique case (kind)
            ACC_PEND_HI: bus_rdata = pend_q[N_SRC-1:HALF];
            ACC_PEND_LO: bus_rdata = pend_q[HALF-1:0];
            ACC_MASK_HI: bus_rdata = mask_q[N_SRC-1:HALF];
            ACC_MASK_LO: bus_rdata = mask_q[HALF-1:0];
            ACC_FRC_HI:  bus_rdata = force_q[N_SRC-1:HALF];
            ACC_FRC_LO:  bus_rdata = force_q[HALF-1:0];
            ACC_CTRL:    bus_rdata = DATA_W'(ctrl_q[idx]);
            ACC_ACK:     bus_rdata = DATA_W'(cpu_vector);
            default:     bus_rdata = '0;
        endcase
    end

    a_r4_idle_vector: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(active) == '0) |-> (cpu_vector == VEC_W'(VEC_IDLE) && cpu_level == '0));

    a_r5_grant_has_level: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_vector != VEC_W'(VEC_IDLE)) |-> (cpu_level != '0));
endmodule

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/100ps
module sim_irq_prio_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_in = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_off = 8'hF0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  cpu_level;
    logic [7:0]  cpu_vector;
    logic        wr_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_prio_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
        .bus_off(bus_off), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_level(cpu_level), .cpu_vector(cpu_vector), .wr_err(wr_err)
    );

    // Behavioural reference model
    logic [63:0] m_pend, m_mask;
    int          m_ctrl [64];
    int          m_lvl, m_vec;
    bit          m_err;

    function automatic bit m_active(int i);
        return m_pend[i] && m_ctrl[i] != 0 && !m_mask[i];
    endfunction

    function automatic bit writable(logic [7:0] o);
        return o == 8'h00 || o == 8'h04 || o == 8'h08 || o == 8'h0C ||
               (o >= 8'h40 && o <= 8'h7F);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pend = '0; m_mask = '1; m_lvl = 0; m_vec = 24; m_err = 0;
            for (int i = 0; i < 64; i++) m_ctrl[i] = 0;
        end else begin
            int best, bl;
            best = -1; bl = 0;
            for (int i = 0; i < 64; i++)
                if (m_active(i) && m_ctrl[i] >= bl) begin bl = m_ctrl[i]; best = i; end
            m_lvl = (best < 0) ? 0 : bl;
            m_vec = (best < 0) ? 24 : best + 64;
            m_err = bus_wr && !writable(bus_off);
            m_pend = irq_in;
            if (bus_wr) begin
                if (bus_off == 8'h08) m_mask[63:32] = bus_wdata;
                if (bus_off == 8'h0C) m_mask[31:0]  = bus_wdata;
                if (bus_off >= 8'h40 && bus_off <= 8'h7F)
                    m_ctrl[bus_off - 8'h40] = int'(bus_wdata[7:0]);
            end
        end
    end

    function automatic logic [31:0] m_read(logic [7:0] o);
        if (o >= 8'h40 && o <= 8'h7F) return 32'(m_ctrl[o - 8'h40]);
        case (o)
            8'h00: return m_pend[63:32];
            8'h04: return m_pend[31:0];
            8'h08: return m_mask[63:32];
            8'h0C: return m_mask[31:0];
            8'hE0: return 32'(m_vec);
            default: return 32'h0;
        endcase
    endfunction

    function automatic string read_tag(logic [7:0] o);
        if (o == 8'h00 || o == 8'h04) return "R1";
        if (o == 8'h08 || o == 8'h0C) return "R6";
        if (o >= 8'h40 && o <= 8'h7F) return "R7";
        return "R9";
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R5 level", 32'(cpu_level), 32'(m_lvl));
            chk("R4 vector", 32'(cpu_vector), 32'(m_vec));
            chk("R10 wr_err", 32'(wr_err), 32'(m_err));
            chk({read_tag(bus_off), " rdata"}, bus_rdata, m_read(bus_off));
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(logic [7:0] o, logic [31:0] d);
        @(negedge clk); #1;
        bus_wr = 1'b1; bus_off = o; bus_wdata = d;
        @(negedge clk); #1;
        bus_wr = 1'b0; bus_off = 8'hF0;
    endtask

    task automatic rd(logic [7:0] o);
        @(negedge clk); #1;
        bus_off = o;
        #0.5;
    endtask

    task automatic out_is(string tag, int lvl, int vec);
        chk({tag, " level"}, 32'(cpu_level), 32'(lvl));
        chk({tag, " vector"}, 32'(cpu_vector), 32'(vec));
    endtask

    initial begin
        step(3);
        out_is("R11", 0, 24);
        chk("R11 wr_err", 32'(wr_err), 0);
        rst_n = 1'b1;
        rd(8'h08); chk("R11 mask hi", bus_rdata, 32'hFFFF_FFFF);
        rd(8'h44); chk("R11 ctrl", bus_rdata, 0);

        irq_in[5] = 1'b1;
        wr(8'h0C, 32'h0);
        step(3); out_is("R2 disabled", 0, 24);
        wr(8'h45, 32'h103);
        step(3); out_is("R2 enabled", 3, 69);
        rd(8'h45); chk("R7 ctrl readback", bus_rdata, 32'h3);
        wr(8'h0C, 32'h20);
        step(3); out_is("R2 masked", 0, 24);
        wr(8'h0C, 32'h0);

        irq_in[10] = 1'b1; wr(8'h4A, 3);
        step(3); out_is("R3 tie", 3, 74);
        irq_in[2] = 1'b1; wr(8'h42, 7);
        step(3); out_is("R3 higher", 7, 66);
        irq_in[40] = 1'b1; wr(8'h68, 7); wr(8'h08, 32'h0);
        step(3); out_is("R3 tie high idx", 7, 104);

        wr(8'h00, 32'hFFFF_FFFF);
        chk("R8 no err", 32'(wr_err), 0);
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04); chk("R8 pend kept", bus_rdata, 32'h0000_0424);
        wr(8'h10, 32'h1);
        chk("R10 err pulse", 32'(wr_err), 1);
        step(1); chk("R10 err clears", 32'(wr_err), 0);
        wr(8'h9C, 32'h5);
        chk("R10 unmapped err", 32'(wr_err), 1);

        rd(8'hE0); chk("R9 ack vector", bus_rdata, 32'd104);
        rd(8'h84); chk("R9 unmapped", bus_rdata, 0);
        rd(8'h14); chk("R9 force", bus_rdata, 0);

        wr(8'h68, 0);
        step(3); out_is("R2 zero byte", 7, 66);
        irq_in = '0;
        step(3); out_is("R4 idle", 0, 24);

        for (int c = 0; c < 3000; c++) begin
            @(negedge clk); #1;
            irq_in = {$urandom, $urandom};
            bus_wr = ($urandom % 3) == 0;
            case ($urandom % 8)
                0: bus_off = 8'h00;
                1: bus_off = 8'h08;
                2: bus_off = 8'h0C;
                3: bus_off = 8'h10;
                4: bus_off = 8'hE0;
                5: bus_off = 8'(($urandom % 256));
                default: bus_off = 8'h40 + 8'(($urandom % 64));
            endcase
            bus_wdata = {$urandom} & (bus_off >= 8'h40 && bus_off <= 8'h7F ? 32'h7 : 32'hFFFF_FFFF);
        end
        bus_wr = 1'b0;

        @(negedge clk); #1; rst_n = 1'b0;
        step(1); out_is("R11 mid reset", 0, 24);
        rd(8'h0C); chk("R11 mask lo", bus_rdata, 32'hFFFF_FFFF);
        rst_n = 1'b1;
        step(4);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule